// File: doc/BRIEF.md
# GPIO Port Direction Controller

This block is one 16-pin general-purpose I/O port with a small register interface. Each pin has a direction bit and an output data latch, both held in registers that software reaches over a simple byte-addressed read/write bus. A per-pin function-select input, driven by the chip's pin-multiplexing logic, decides whether the pin is owned by this GPIO port or by some other peripheral. For GPIO-owned pins the direction bit and the latch drive the pad. For the other pins the alternate function's output-enable and output-value pass straight through.

Pad inputs pass through a two-flop synchronizer before they can be read back. A data-register read merges two sources per pin. A GPIO pin driven as an output returns its latch. Every other pin returns its synchronized pad level. The port's internal pull-ups are on after reset. They switch off for good on the first write to the direction register, and only a reset turns them back on.

Top module: `gpio_dir_port`

## Requirements
- R1: After reset every direction bit and every latch bit is 0, a GPIO-owned pin has its output enable low, and `pullUpEn` is 1.
- R2: For a pin with `pinGpioSel` = 1, a direction bit of 1 sets `padOutEn` high and a direction bit of 0 sets it low. The change is visible from the clock edge that accepts the direction write.
- R3: For a pin with `pinGpioSel` = 0, `padOutEn` equals `altOutEn` and `padOutVal` equals `altOutVal`, whatever its direction bit or latch holds.
- R4: The latch is written independently of the direction. A GPIO-owned pin's `padOutVal` always shows its latch. A value written while the pin is an input is therefore driven as soon as the pin becomes an output.
- R5: `pullUpEn` drops at the same edge that accepts the first direction write with at least one byte lane enabled. It stays low through later writes until reset. Data writes never affect it.
- R6: Byte offset 0x04 is the direction register and byte offset 0x00 is the data register. A read returns its data on `busRdData` one cycle after `busRdEn`. `busRdData` is 0 in any cycle that follows a cycle without a read. A direction read returns the direction bits.
- R7: A data read returns the latch bit for each pin that is GPIO-owned with direction 1. Every other pin returns the pad level after a two-flop synchronizer.
- R8: Write byte enables select lanes. `busByteEn[0]` covers bits 7:0 and `busByteEn[1]` covers bits 15:8. Disabled lanes keep their contents.
- R9: A write to an unmapped offset, for example 0x08, changes no register. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | 8 | Byte address of the access |
| busByteEn | input | 2 | Write byte-lane enables |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, registered |
| pinGpioSel | input | 16 | Per pin: 1 = owned by GPIO, 0 = alternate function |
| altOutEn | input | 16 | Alternate function output enables |
| altOutVal | input | 16 | Alternate function output values |
| padIn | input | 16 | Asynchronous pad input levels |
| padOutEn | output | 16 | Per-pin output enable to the pad |
| padOutVal | output | 16 | Per-pin output value to the pad |
| pullUpEn | output | 1 | Enable for the port's internal pull-ups |

## Verification
The hardest case to reach is a data read where the three per-pin sources mix: some pins are GPIO outputs, some are GPIO inputs, and some are alternate-function pins, while the pad carries a pattern different from the latch. The stimulus sets up that mix by programming the latch and direction with contrasting patterns. It then changes the function-select mask with no further register write and holds the pad steady long enough to cross the synchronizer before reading. The one-shot pull-up behaviour gets its own check. It is checked before any direction write, after a data-only write, after repeated direction writes, and again after a reset in the middle of the run.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;

  // Decoded register strobes passed from control to datapath.
  typedef struct packed {
    logic dirWr;
    logic dataWr;
    logic rdDir;
    logic rdData;
  } ctrlStrb_t;

endpackage

// File: rtl/gpio_dir_ctrl.sv
module gpio_dir_ctrl
  import gpio_dir_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_OFF = 'h00,
  parameter int DIR_OFF  = 'h04
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrb_t         strb
);

  localparam logic [ADDR_W-1:0] DataAddr = ADDR_W'(DATA_OFF);
  localparam logic [ADDR_W-1:0] DirAddr  = ADDR_W'(DIR_OFF);

  logic hitData;
  logic hitDir;

  always_comb begin
    hitData     = (busAddr == DataAddr);
    hitDir      = (busAddr == DirAddr);
    strb.dirWr  = busWrEn && hitDir;
    strb.dataWr = busWrEn && hitData;
    strb.rdDir  = busRdEn && hitDir;
    strb.rdData = busRdEn && hitData;
  end

endmodule

// File: rtl/gpio_dir_datapath.sv
module gpio_dir_datapath
  import gpio_dir_pkg::*;
#(
  parameter int PIN_N  = 16,
  parameter int LANE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [PIN_N/LANE_W-1:0]  laneEn,
  input  logic [PIN_N-1:0]         wrData,
  input  logic [PIN_N-1:0]         pinGpioSel,
  input  logic [PIN_N-1:0]         altOutEn,
  input  logic [PIN_N-1:0]         altOutVal,
  input  logic [PIN_N-1:0]         padIn,
  output logic [PIN_N-1:0]         padOutEn,
  output logic [PIN_N-1:0]         padOutVal,
  output logic [PIN_N-1:0]         rdData,
  output logic                     pullUpEn
);

  localparam int LaneN = PIN_N / LANE_W;

  logic [PIN_N-1:0] dirQ, dirD;
  logic [PIN_N-1:0] latchQ, latchD;
  logic [PIN_N-1:0] laneMask;
  logic             pullOffQ;
  logic [PIN_N-1:0] syncQ [SYNC_N];
  logic [PIN_N-1:0] syncOut;
  logic [PIN_N-1:0] drvMask;
  logic [PIN_N-1:0] rdNext;

  // Expand byte-lane enables into a bit mask.
  for (genvar l = 0; l < LaneN; l++) begin : gLane
    assign laneMask[l*LANE_W +: LANE_W] = {LANE_W{laneEn[l]}};
  end

  always_comb begin
    dirD   = strb.dirWr  ? ((dirQ   & ~laneMask) | (wrData & laneMask)) : dirQ;
    latchD = strb.dataWr ? ((latchQ & ~laneMask) | (wrData & laneMask)) : latchQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ     <= '0;
      latchQ   <= '0;
      pullOffQ <= 1'b0;
    end else begin
      dirQ   <= dirD;
      latchQ <= latchD;
      if (strb.dirWr && (|laneEn)) pullOffQ <= 1'b1;
    end
  end

  // Pad input synchronizer chain.
  for (genvar s = 0; s < SYNC_N; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= padIn;
      else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end
  assign syncOut = syncQ[SYNC_N-1];

  // Per-pin output muxing between GPIO and alternate function.
  for (genvar p = 0; p < PIN_N; p++) begin : gPin
    always_comb begin
      if (pinGpioSel[p]) begin
        padOutEn[p]  = dirQ[p];
        padOutVal[p] = latchQ[p];
      end else begin
        padOutEn[p]  = altOutEn[p];
        padOutVal[p] = altOutVal[p];
      end
    end
  end

  always_comb begin
    drvMask = pinGpioSel & dirQ;
    if (strb.rdDir)       rdNext = dirQ;
    else if (strb.rdData) rdNext = (latchQ & drvMask) | (syncOut & ~drvMask);
    else                  rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assign pullUpEn = !pullOffQ;

endmodule

// File: rtl/gpio_dir_port.sv
module gpio_dir_port
  import gpio_dir_pkg::*;
#(
  parameter int PIN_N    = 16,
  parameter int ADDR_W   = 8,
  parameter int LANE_W   = 8,
  parameter int DATA_OFF = 'h00,
  parameter int DIR_OFF  = 'h04
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWrEn,
  input  logic                    busRdEn,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [PIN_N/LANE_W-1:0] busByteEn,
  input  logic [PIN_N-1:0]        busWrData,
  output logic [PIN_N-1:0]        busRdData,
  input  logic [PIN_N-1:0]        pinGpioSel,
  input  logic [PIN_N-1:0]        altOutEn,
  input  logic [PIN_N-1:0]        altOutVal,
  input  logic [PIN_N-1:0]        padIn,
  output logic [PIN_N-1:0]        padOutEn,
  output logic [PIN_N-1:0]        padOutVal,
  output logic                    pullUpEn
);

  ctrlStrb_t strb;

  gpio_dir_ctrl #(
    .ADDR_W(ADDR_W), .DATA_OFF(DATA_OFF), .DIR_OFF(DIR_OFF)
  ) ctrl_i (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .strb(strb)
  );

  gpio_dir_datapath #(
    .PIN_N(PIN_N), .LANE_W(LANE_W), .SYNC_N(2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .laneEn(busByteEn),
    .wrData(busWrData), .pinGpioSel(pinGpioSel), .altOutEn(altOutEn),
    .altOutVal(altOutVal), .padIn(padIn), .padOutEn(padOutEn),
    .padOutVal(padOutVal), .rdData(busRdData), .pullUpEn(pullUpEn)
  );

endmodule

// File: rtl/gpio_dir_port_chk.sv
module gpio_dir_port_chk #(
  parameter int PIN_N    = 16,
  parameter int ADDR_W   = 8,
  parameter int LANE_W   = 8,
  parameter int DATA_OFF = 'h00,
  parameter int DIR_OFF  = 'h04
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    busWrEn,
  input logic                    busRdEn,
  input logic [ADDR_W-1:0]       busAddr,
  input logic [PIN_N/LANE_W-1:0] busByteEn,
  input logic [PIN_N-1:0]        pinGpioSel,
  input logic [PIN_N-1:0]        padOutEn,
  input logic [PIN_N-1:0]        padOutVal,
  input logic [PIN_N-1:0]        busRdData,
  input logic                    pullUpEn
);

  logic dirWrNow, dataWrNow, mappedRd;
  assign dirWrNow  = busWrEn && (busAddr == ADDR_W'(DIR_OFF));
  assign dataWrNow = busWrEn && (busAddr == ADDR_W'(DATA_OFF));
  assign mappedRd  = (busAddr == ADDR_W'(DIR_OFF)) || (busAddr == ADDR_W'(DATA_OFF));

  // R5: pull-ups stay off once off
  a_r5_pullup_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !pullUpEn |=> !pullUpEn);

  // R5: a direction write with a lane enabled turns pull-ups off
  a_r5_pullup_drop: assert property (@(posedge clk) disable iff (!rstN)
    (dirWrNow && (|busByteEn)) |=> !pullUpEn);

  // R2: without a direction write, GPIO-owned enables hold
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dirWrNow |=> ((pinGpioSel != $past(pinGpioSel)) ||
                   ((padOutEn & pinGpioSel) == ($past(padOutEn) & pinGpioSel))));

  // R4: without a data write, GPIO-owned output values hold
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrNow |=> ((pinGpioSel != $past(pinGpioSel)) ||
                    ((padOutVal & pinGpioSel) == ($past(padOutVal) & pinGpioSel))));

  // R6: no read means zero read data next cycle
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> (busRdData == '0));

  // R9: unmapped reads return zero
  a_r9_unmapped_rd: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !mappedRd) |=> (busRdData == '0));

endmodule

bind gpio_dir_port gpio_dir_port_chk #(
  .PIN_N(PIN_N), .ADDR_W(ADDR_W), .LANE_W(LANE_W),
  .DATA_OFF(DATA_OFF), .DIR_OFF(DIR_OFF)
) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busByteEn(busByteEn), .pinGpioSel(pinGpioSel),
  .padOutEn(padOutEn), .padOutVal(padOutVal), .busRdData(busRdData),
  .pullUpEn(pullUpEn)
);

// File: tb/gpio_dir_port_tb_top.sv
module gpio_dir_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busByteEn = '0;
  logic [15:0] busWrData = '0, busRdData;
  logic [15:0] pinGpioSel = '0, altOutEn = '0, altOutVal = '0, padIn = '0;
  logic [15:0] padOutEn, padOutVal;
  logic        pullUpEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_dir_port dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWrData(busWrData),
    .busRdData(busRdData), .pinGpioSel(pinGpioSel), .altOutEn(altOutEn),
    .altOutVal(altOutVal), .padIn(padIn), .padOutEn(padOutEn),
    .padOutVal(padOutVal), .pullUpEn(pullUpEn)
  );

  localparam logic [7:0] A_DATA = 8'h00;
  localparam logic [7:0] A_DIR  = 8'h04;
  localparam logic [7:0] A_NONE = 8'h08;

  // sel, dir, dat, altEn, altVal, expEn, expVal
  localparam logic [15:0] VEC [4][7] = '{
    '{16'hFFFF, 16'h00FF, 16'hA5A5, 16'h0000, 16'h0000, 16'h00FF, 16'hA5A5},
    '{16'hFF00, 16'h0F0F, 16'h1234, 16'h00F0, 16'h0033, 16'h0FF0, 16'h1233},
    '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h5555, 16'h0F0F, 16'h5555, 16'h0F0F},
    '{16'hF0F0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0F0F}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d; busByteEn = be;
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  initial begin
    logic [15:0] rd;
    pinGpioSel = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outEn", padOutEn, 16'h0000);
    check("R1 outVal", padOutVal, 16'h0000);
    check("R1 pullUp", {15'd0, pullUpEn}, 16'h0001);
    rstN = 1'b1;
    busRead(A_DIR, rd);
    check("R1 dir read", rd, 16'h0000);

    // R4: latch written while pins are inputs
    busWrite(A_DATA, 16'hBEEF, 2'b11);
    check("R4 still input", padOutEn, 16'h0000);
    check("R5 data write keeps pullUp", {15'd0, pullUpEn}, 16'h0001);
    busWrite(A_DIR, 16'h00FF, 2'b11);
    check("R2 outEn", padOutEn, 16'h00FF);
    check("R4 held value", padOutVal, 16'hBEEF);
    check("R5 pullUp drops", {15'd0, pullUpEn}, 16'h0000);
    busWrite(A_DIR, 16'h0000, 2'b11);
    check("R5 pullUp stays off", {15'd0, pullUpEn}, 16'h0000);
    check("R2 back to input", padOutEn, 16'h0000);
    @(negedge clk);
    check("R6 idle zero", busRdData, 16'h0000);

    // Vector table: R2, R3, R4, R6
    for (int i = 0; i < 4; i++) begin
      busWrite(A_DATA, VEC[i][2], 2'b11);
      busWrite(A_DIR, VEC[i][1], 2'b11);
      @(negedge clk);
      pinGpioSel = VEC[i][0]; altOutEn = VEC[i][3]; altOutVal = VEC[i][4];
      #1;
      check($sformatf("R2 R3 vec%0d outEn", i), padOutEn, VEC[i][5]);
      check($sformatf("R3 R4 vec%0d outVal", i), padOutVal, VEC[i][6]);
      busRead(A_DIR, rd);
      check($sformatf("R6 vec%0d dir read", i), rd, VEC[i][1]);
    end

    // R8: byte lanes
    busWrite(A_DIR, 16'h0000, 2'b11);
    busWrite(A_DIR, 16'hABCD, 2'b01);
    busRead(A_DIR, rd);
    check("R8 low lane", rd, 16'h00CD);
    busWrite(A_DIR, 16'h1200, 2'b10);
    busRead(A_DIR, rd);
    check("R8 high lane", rd, 16'h12CD);

    // R7: mixed data read
    pinGpioSel = 16'hFFFF;
    busWrite(A_DIR, 16'h00FF, 2'b11);
    busWrite(A_DATA, 16'h3C3C, 2'b11);
    @(negedge clk);
    padIn = 16'hA5A5;
    repeat (3) @(negedge clk);
    busRead(A_DATA, rd);
    check("R7 outputs and inputs", rd, 16'hA53C);
    pinGpioSel = 16'hFF0F;
    busRead(A_DATA, rd);
    check("R7 alternate pins read pad", rd, 16'hA5AC);

    // R9: unmapped access
    busWrite(A_NONE, 16'hFFFF, 2'b11);
    busRead(A_DIR, rd);
    check("R9 dir untouched", rd, 16'h00FF);
    busRead(A_DATA, rd);
    check("R9 data untouched", rd, 16'hA5AC);
    busRead(A_NONE, rd);
    check("R9 unmapped read", rd, 16'h0000);

    // R5/R1: reset restores pull-ups
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R5 pullUp after reset", {15'd0, pullUpEn}, 16'h0001);
    busRead(A_DIR, rd);
    check("R1 dir after reset", rd, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule